// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block keeps the memory operations of an out-of-order core in program order while they are in flight. Each load or store takes a slot when it issues. The slot index is returned to the core. The core then fills in the resolved address and, for stores, the data value through that index. A store's address and data stay in the queue until the store commits at the head of the queue. Only then are they written into the data cache. Because of this, committed memory state never holds a value from a speculative store.

A load whose address is known does not wait for commit. It scans the stores that are older than itself and whose addresses are already resolved. If any of them match, the load takes the value of the youngest matching store. If none match, the load reads the cache through a synchronous read port. Each load result leaves on a single result port, one cycle after the load is picked, and carries the load's tag. A flush discards every uncommitted entry after an exception or misprediction.

Top module: `lsq_fwd_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` follows `rob_free`, and `res_valid`, `cache_wr_en` and `cache_rd_en` are all low.
- R2: Slots are handed out in program order. `alloc_idx` starts at 0 after reset or flush and steps by one modulo DEPTH for each accepted allocation. Entries leave only from the oldest end.
- R3: A store drives `cache_wr_en` with its address and data only in the cycle it commits at the head, and only after both its address and its data are known. The cache is never written earlier.
- R4: A load may be picked once its address is known. If no older store with a known address matches, the load raises `cache_rd_en` with its address in that cycle. In the next cycle `res_valid` is high, `res_tag` carries the load's tag and `res_data` equals `cache_rd_data`.
- R5: When older stores with known addresses match the load, the load takes the data of the youngest of them. No cache read is made, and the result appears one cycle after the pick.
- R6: Older loads to the same address play no part in the search. Older stores whose address is still unknown are passed over, and the load proceeds without them.
- R7: `alloc_ready` is high only when a free queue slot exists and `rob_free` is high. It is low when all DEPTH slots hold entries.
- R8: If the youngest matching older store has no data yet, the load is held. It is retried every cycle and is picked in the cycle after the store data arrives.
- R9: Each cycle the oldest load that can proceed is picked, and at most one result leaves per cycle. A held load does not block younger loads.
- R10: `flush` empties the queue. It resets the slot counter to 0, suppresses any commit, pick or allocation in that cycle, and clears the pending result. The cache keeps its committed contents.
- R11: `commit_valid` has no effect when the queue is empty or when the head is not complete. A load at the head is complete once it has been picked. A store at the head is complete once both its address and its data are known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all uncommitted entries |
| rob_free | input | 1 | Reorder buffer has a free entry |
| alloc_valid | input | 1 | Request to allocate a slot |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_tag | input | 8 | Sequence tag of the operation |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | 3 | Slot given to the allocating operation |
| addr_valid | input | 1 | Address update strobe |
| addr_idx | input | 3 | Slot whose address is resolved |
| addr_value | input | 16 | Resolved address |
| data_valid | input | 1 | Store data update strobe |
| data_idx | input | 3 | Store slot receiving data |
| data_value | input | 32 | Store data |
| commit_valid | input | 1 | Commit the head entry |
| cache_wr_en | output | 1 | Cache write strobe (store commit) |
| cache_wr_addr | output | 16 | Cache write address |
| cache_wr_data | output | 32 | Cache write data |
| cache_rd_en | output | 1 | Cache read strobe |
| cache_rd_addr | output | 16 | Cache read address |
| cache_rd_data | input | 32 | Cache read data, valid the cycle after `cache_rd_en` |
| res_valid | output | 1 | Load result valid |
| res_tag | output | 8 | Tag of the finished load |
| res_data | output | 32 | Loaded value |

## Verification
The bench builds the queue with its default of eight slots, a 16-bit address and 32-bit data. A small queue fills within a few allocations, so the full condition and the pointer wrap are exercised many times. The random phase draws addresses from only six values, which keeps several uncommitted stores to one address in the queue at once. Together these reach the youngest-store choice, held loads overtaken by younger ones, and flushes landing on a full queue.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    parameter int AW = 16;
    parameter int DW = 32;
    parameter int TW = 8;

    typedef struct packed {
        logic          used;
        logic          is_store;
        logic [TW-1:0] tag;
        logic          addr_ok;
        logic [AW-1:0] addr;
        logic          val_ok;
        logic [DW-1:0] data;
        logic          done;
    } lsq_ent_t;

    // Head entry may retire: loads once picked, stores once address and data are known
    function automatic logic ent_complete(input lsq_ent_t e);
        return e.used && (e.is_store ? (e.addr_ok && e.val_ok) : e.done);
    endfunction

endpackage

// File: rtl/lsq_st_search.sv
// Scans the entries older than slot SELF for stores to the same address; the
// last match seen in age order is the youngest one.
module lsq_st_search #(
    parameter  int DEPTH = 8,
    parameter  int SELF  = 0,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]                      head,
    input  logic [DEPTH-1:0]                   used,
    input  logic [DEPTH-1:0]                   is_st,
    input  logic [DEPTH-1:0]                   a_ok,
    input  logic [DEPTH-1:0]                   v_ok,
    input  logic [DEPTH-1:0][lsq_pkg::AW-1:0]  addrs,
    input  logic [DEPTH-1:0][lsq_pkg::DW-1:0]  datas,
    output logic                               hit,
    output logic                               blocked,
    output logic [lsq_pkg::DW-1:0]             fwd_data
);

    always_comb begin
        logic          seen;
        logic [IW-1:0] idx;
        seen     = 1'b0;
        hit      = 1'b0;
        blocked  = 1'b0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IW'(k);
            if (idx == IW'(SELF)) seen = 1'b1;
            if (!seen && used[idx] && is_st[idx] && a_ok[idx] &&
                addrs[idx] == addrs[SELF]) begin
                hit      = 1'b1;
                blocked  = !v_ok[idx];
                fwd_data = datas[idx];
            end
        end
    end

endmodule

// File: rtl/lsq_oldest_pick.sv
// Selects the ready slot closest to the head.
module lsq_oldest_pick #(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] ready,
    output logic             any,
    output logic [IW-1:0]    sel
);

    always_comb begin
        logic [IW-1:0] idx;
        any = 1'b0;
        sel = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head + IW'(k);
            if (ready[idx]) begin
                any = 1'b1;
                sel = idx;
            end
        end
    end

    AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (rst)
        any |-> ready[sel]);  // R9

endmodule

// File: rtl/lsq_fwd_queue.sv
module lsq_fwd_queue
    import lsq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = IW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   rob_free,
    input  logic                   alloc_valid,
    input  logic                   alloc_is_store,
    input  logic [lsq_pkg::TW-1:0] alloc_tag,
    output logic                   alloc_ready,
    output logic [IW-1:0]          alloc_idx,
    input  logic                   addr_valid,
    input  logic [IW-1:0]          addr_idx,
    input  logic [lsq_pkg::AW-1:0] addr_value,
    input  logic                   data_valid,
    input  logic [IW-1:0]          data_idx,
    input  logic [lsq_pkg::DW-1:0] data_value,
    input  logic                   commit_valid,
    output logic                   cache_wr_en,
    output logic [lsq_pkg::AW-1:0] cache_wr_addr,
    output logic [lsq_pkg::DW-1:0] cache_wr_data,
    output logic                   cache_rd_en,
    output logic [lsq_pkg::AW-1:0] cache_rd_addr,
    input  logic [lsq_pkg::DW-1:0] cache_rd_data,
    output logic                   res_valid,
    output logic [lsq_pkg::TW-1:0] res_tag,
    output logic [lsq_pkg::DW-1:0] res_data
);

    lsq_ent_t                 ents [DEPTH];
    logic [CW-1:0]            head_q, tail_q, cnt;
    logic [IW-1:0]            head_i, tail_i;
    logic                     full, empty;
    logic                     alloc_fire, commit_fire, pick_any, pick_fire;
    logic [IW-1:0]            pick_sel;
    lsq_ent_t                 head_e;

    logic [DEPTH-1:0]         v_used, v_st, v_aok, v_vok, v_done;
    logic [DEPTH-1:0]         v_hit, v_blk, v_ready;
    logic [DEPTH-1:0][AW-1:0] v_addr;
    logic [DEPTH-1:0][DW-1:0] v_data, v_fwd;

    logic                     res_v_q, res_fwd_q;
    logic [TW-1:0]            res_tag_q;
    logic [DW-1:0]            res_fdata_q;

    assign head_i = head_q[IW-1:0];
    assign tail_i = tail_q[IW-1:0];
    assign cnt    = tail_q - head_q;
    assign full   = (cnt == CW'(DEPTH));
    assign empty  = (cnt == '0);
    assign head_e = ents[head_i];

    // One search unit per slot; a load is ready when no matching store blocks it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign v_used[g] = ents[g].used;
        assign v_st[g]   = ents[g].is_store;
        assign v_aok[g]  = ents[g].addr_ok;
        assign v_vok[g]  = ents[g].val_ok;
        assign v_done[g] = ents[g].done;
        assign v_addr[g] = ents[g].addr;
        assign v_data[g] = ents[g].data;

        lsq_st_search #(.DEPTH(DEPTH), .SELF(g)) u_search (
            .head     (head_i),
            .used     (v_used),
            .is_st    (v_st),
            .a_ok     (v_aok),
            .v_ok     (v_vok),
            .addrs    (v_addr),
            .datas    (v_data),
            .hit      (v_hit[g]),
            .blocked  (v_blk[g]),
            .fwd_data (v_fwd[g])
        );

        assign v_ready[g] = v_used[g] && !v_st[g] && v_aok[g] && !v_done[g] && !v_blk[g];
    end

    lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .head  (head_i),
        .ready (v_ready),
        .any   (pick_any),
        .sel   (pick_sel)
    );

    assign alloc_ready = !full && rob_free && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail_i;
    assign commit_fire = commit_valid && !flush && !empty && ent_complete(head_e);
    assign pick_fire   = pick_any && !flush;

    assign cache_wr_en   = commit_fire && head_e.is_store;
    assign cache_wr_addr = head_e.addr;
    assign cache_wr_data = head_e.data;
    assign cache_rd_en   = pick_fire && !v_hit[pick_sel];
    assign cache_rd_addr = ents[pick_sel].addr;

    assign res_valid = res_v_q;
    assign res_tag   = res_tag_q;
    assign res_data  = res_fwd_q ? res_fdata_q : cache_rd_data;

    always_ff @(posedge clk) begin
        res_tag_q   <= ents[pick_sel].tag;
        res_fwd_q   <= v_hit[pick_sel];
        res_fdata_q <= v_fwd[pick_sel];
        if (rst || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            res_v_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else begin
            res_v_q <= pick_fire;
            if (commit_fire) begin
                ents[head_i].used <= 1'b0;
                head_q            <= head_q + CW'(1);
            end
            if (addr_valid && ents[addr_idx].used) begin
                ents[addr_idx].addr_ok <= 1'b1;
                ents[addr_idx].addr    <= addr_value;
            end
            if (data_valid && ents[data_idx].used && ents[data_idx].is_store) begin
                ents[data_idx].val_ok <= 1'b1;
                ents[data_idx].data   <= data_value;
            end
            if (pick_fire) ents[pick_sel].done <= 1'b1;
            if (alloc_fire) begin
                ents[tail_i] <= '{used: 1'b1, is_store: alloc_is_store,
                                  tag: alloc_tag, default: '0};
                tail_q       <= tail_q + CW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));  // R2
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ready);  // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0 && !res_valid));  // R10
    AST_RD_THEN_RESULT: assert property (@(posedge clk) disable iff (rst)
        cache_rd_en |=> res_valid);  // R4
    AST_WR_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        cache_wr_en |=> (head_q == $past(head_q) + CW'(1)));  // R3

endmodule

// File: tb/lsq_fwd_queue_tb_top.sv
module lsq_fwd_queue_tb_top;
    import lsq_pkg::*;

    localparam int DEPTH = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0, rst = 1'b1;
    logic          flush, rob_free, alloc_valid, alloc_is_store;
    logic [TW-1:0] alloc_tag;
    logic          alloc_ready;
    logic [IW-1:0] alloc_idx, addr_idx, data_idx;
    logic          addr_valid, data_valid, commit_valid;
    logic [AW-1:0] addr_value, cache_wr_addr, cache_rd_addr;
    logic [DW-1:0] data_value, cache_wr_data, cache_rd_data, res_data;
    logic          cache_wr_en, cache_rd_en, res_valid;
    logic [TW-1:0] res_tag;

    logic [DW-1:0] mem [0:255];

    always #5 clk = ~clk;

    lsq_fwd_queue #(.DEPTH(DEPTH)) dut_i (.*);

    always @(posedge clk) begin
        if (cache_wr_en) mem[cache_wr_addr[7:0]] <= cache_wr_data;
        if (cache_rd_en) cache_rd_data <= mem[cache_rd_addr[7:0]];
    end

    typedef struct {
        int          slot;
        bit          st;
        int          tag;
        bit          aok;
        int          addr;
        bit          vok;
        logic [31:0] data;
        bit          done;
    } rec_t;

    rec_t        q[$];
    int          tail_m, tagc, checks, errors;
    logic [31:0] last_data;

    function automatic logic [31:0] init_val(input int a);
        return 32'h0000_1000 + 32'(a * 5);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        flush = 0; rob_free = 1; alloc_valid = 0; alloc_is_store = 0; alloc_tag = '0;
        addr_valid = 0; addr_idx = '0; addr_value = '0;
        data_valid = 0; data_idx = '0; data_value = '0; commit_valid = 0;
    endtask

    // One clock: predict and check pre-edge outputs, advance the model, check results
    task automatic cyc();
        bit          exp_rdy, hc, cfire, found, fwd, m, blk, ev;
        int          p, ps, et;
        logic [31:0] fd, d, ed;
        #1;
        exp_rdy = !flush && rob_free && q.size() < DEPTH;
        chk(alloc_ready == exp_rdy, "R7 alloc_ready", alloc_ready, exp_rdy);
        if (alloc_valid && exp_rdy) chk(alloc_idx == IW'(tail_m), "R2 alloc_idx", alloc_idx, tail_m);
        hc    = q.size() > 0 && (q[0].st ? (q[0].aok && q[0].vok) : q[0].done);
        cfire = commit_valid && !flush && hc;
        chk(cache_wr_en == (cfire && q[0].st), "R3 R11 cache_wr_en", cache_wr_en, cfire && q[0].st);
        if (cfire && q[0].st) begin
            chk(cache_wr_addr == AW'(q[0].addr), "R3 cache_wr_addr", cache_wr_addr, q[0].addr);
            chk(cache_wr_data == q[0].data, "R3 cache_wr_data", cache_wr_data, q[0].data);
        end
        found = 0; fwd = 0; p = -1; fd = '0;
        if (!flush) begin
            for (int i = 0; i < q.size() && !found; i++) begin
                if (!q[i].st && q[i].aok && !q[i].done) begin
                    m = 0; blk = 0; d = '0;
                    for (int j = 0; j < i; j++)
                        if (q[j].st && q[j].aok && q[j].addr == q[i].addr) begin
                            m = 1; blk = !q[j].vok; d = q[j].data;
                        end
                    if (!blk) begin
                        found = 1; p = i; fwd = m;
                        fd = m ? d : mem[q[i].addr[7:0]];
                    end
                end
            end
        end
        chk(cache_rd_en == (found && !fwd), "R4 R5 cache_rd_en", cache_rd_en, found && !fwd);
        if (found && !fwd) chk(cache_rd_addr == AW'(q[p].addr), "R4 cache_rd_addr", cache_rd_addr, q[p].addr);
        ps = found ? q[p].slot : -1;
        ev = found; et = found ? q[p].tag : 0; ed = fd;
        @(posedge clk);
        if (flush) begin
            q.delete();
            tail_m = 0;
        end else begin
            if (cfire) void'(q.pop_front());
            if (addr_valid)
                foreach (q[i]) if (q[i].slot == int'(addr_idx)) begin
                    q[i].aok = 1; q[i].addr = int'(addr_value);
                end
            if (data_valid)
                foreach (q[i]) if (q[i].slot == int'(data_idx) && q[i].st) begin
                    q[i].vok = 1; q[i].data = data_value;
                end
            if (found) foreach (q[i]) if (q[i].slot == ps) q[i].done = 1;
            if (alloc_valid && exp_rdy) begin
                q.push_back('{slot: tail_m, st: alloc_is_store, tag: int'(alloc_tag),
                              aok: 0, addr: 0, vok: 0, data: '0, done: 0});
                tail_m = (tail_m + 1) % DEPTH;
            end
        end
        @(negedge clk);
        chk(res_valid == ev, "R4 R5 R8 R9 res_valid", res_valid, ev);
        if (ev) begin
            chk(res_tag == TW'(et), "R9 res_tag", res_tag, et);
            chk(res_data == ed, "R5 R6 res_data", res_data, ed);
            last_data = res_data;
        end
    endtask

    task automatic do_alloc(input bit st, output int slot);
        clr(); alloc_valid = 1; alloc_is_store = st; alloc_tag = TW'(tagc); tagc++;
        slot = tail_m;
        cyc(); clr();
    endtask

    task automatic do_addr(input int s, input int a);
        clr(); addr_valid = 1; addr_idx = IW'(s); addr_value = AW'(a); cyc(); clr();
    endtask

    task automatic do_data(input int s, input logic [31:0] v);
        clr(); data_valid = 1; data_idx = IW'(s); data_value = v; cyc(); clr();
    endtask

    task automatic do_commit();
        clr(); commit_valid = 1; cyc(); clr();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin clr(); cyc(); end
    endtask

    initial begin
        int s0, s1, s2, s3, s4, s5, s6, s7, sa, sb, sc;
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        cache_rd_data = '0;
        checks = 0; errors = 0; tagc = 1; tail_m = 0; last_data = '0;
        clr();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
        chk(res_valid == 0, "R1 res_valid", res_valid, 0);
        chk(cache_wr_en == 0 && cache_rd_en == 0, "R1 cache strobes", {cache_wr_en, cache_rd_en}, 0);
        @(negedge clk);

        // Plain load, no stores in flight
        do_alloc(0, s0); do_addr(s0, 'h20); idle(1);
        chk(last_data == init_val('h20), "R4 load from cache", last_data, init_val('h20));

        // Two stores to one address: youngest wins
        do_alloc(1, s1); do_alloc(1, s2);
        do_addr(s1, 'h30); do_addr(s2, 'h30);
        do_data(s1, 32'd111); do_data(s2, 32'd222);
        do_alloc(0, s3); do_addr(s3, 'h30); idle(1);
        chk(last_data == 32'd222, "R5 youngest store forwarded", last_data, 222);

        // Older load to same address is no source; unresolved store is passed over
        do_alloc(0, s4); do_addr(s4, 'h30); idle(1);
        chk(last_data == 32'd222, "R6 older load ignored", last_data, 222);
        do_alloc(1, s5);
        do_alloc(0, s6); do_addr(s6, 'h40); idle(1);
        chk(last_data == init_val('h40), "R6 unresolved store passed over", last_data, init_val('h40));

        do_alloc(0, s7);
        clr(); alloc_valid = 1; #1;
        chk(alloc_ready == 0, "R7 full queue refuses", alloc_ready, 0);
        cyc(); clr();
        chk(mem['h30] == init_val('h30), "R3 no write before commit", mem['h30], init_val('h30));

        repeat (5) do_commit();
        chk(mem['h30] == 32'd222, "R3 committed value in cache", mem['h30], 222);

        clr(); commit_valid = 1; #1;
        chk(cache_wr_en == 0, "R11 incomplete head not committed", cache_wr_en, 0);
        cyc(); clr();

        clr(); flush = 1; cyc(); clr();
        clr(); alloc_valid = 1; alloc_tag = TW'(tagc); tagc++; #1;
        chk(alloc_idx == 0, "R10 slot counter restarts", alloc_idx, 0);
        s0 = tail_m; cyc(); clr();
        do_addr(s0, 'h30); idle(1);
        chk(last_data == 32'd222, "R10 cache keeps committed data", last_data, 222);
        do_commit();

        // Held load overtaken by a younger one, then released
        do_alloc(1, sa); do_addr(sa, 'h50);
        do_alloc(0, sb); do_addr(sb, 'h50);
        do_alloc(0, sc); do_addr(sc, 'h60); idle(1);
        chk(last_data == init_val('h60), "R9 younger load passes held one", last_data, init_val('h60));
        idle(2);
        do_data(sa, 32'd77); idle(1);
        chk(last_data == 32'd77, "R8 held load gets late store data", last_data, 77);

        clr(); rob_free = 0; alloc_valid = 1; #1;
        chk(alloc_ready == 0, "R7 no reorder buffer room", alloc_ready, 0);
        cyc(); clr();
        clr(); flush = 1; cyc(); clr();

        // Random mix compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int i;
            clr();
            if ($urandom % 48 == 0) flush = 1;
            else begin
                rob_free       = ($urandom % 8) != 0;
                alloc_valid    = $urandom % 2;
                alloc_is_store = $urandom % 2;
                alloc_tag      = TW'(tagc); tagc++;
                if (q.size() > 0 && $urandom % 2) begin
                    i = $urandom % q.size();
                    if (!q[i].aok) begin
                        addr_valid = 1; addr_idx = IW'(q[i].slot);
                        addr_value = AW'('h10 + $urandom % 6);
                    end
                end
                if (q.size() > 0 && $urandom % 2) begin
                    i = $urandom % q.size();
                    if (q[i].st && !q[i].vok) begin
                        data_valid = 1; data_idx = IW'(q[i].slot); data_value = $urandom;
                    end
                end
                commit_valid = ($urandom % 3) == 0;
            end
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule